// File: doc/BRIEF.md
# DMA Block-Transfer Sequencer

This block generates the addresses and tracks the counts for one DMA channel that moves data in blocks. Software loads a source address, a destination address, a block length M (transfers per block) and a number of blocks N. It also picks the transfer width and, for each side, whether that address moves and in which direction. It then enables the channel. Each request that arrives while the channel is enabled and idle starts a burst of M back-to-back transfers, which is one block. Each transfer is presented to a simple memory port as a read strobe on the source address and a write strobe on the destination address.

One of the two addresses is chosen as the block area. At the end of every block that address returns to its loaded value, while the other address keeps advancing across block boundaries. When the last block completes, the channel disables itself and, if enabled, raises a sticky interrupt. Software clears the interrupt with a pulse. The current addresses, the in-block count and the remaining block count can be read at the ports at any time.

Top module: `blk_dma_seq`

## Requirements
- R1: The in-block count (`sts_inner`) decreases by one on every completed transfer. A transfer completes on a rising edge where `active` and `mem_rdy` are both high.
- R2: One accepted request produces exactly M transfers of one burst. With `mem_rdy` held high they occur on consecutive cycles, and `active` then falls by itself.
- R3: On the transfer that takes the in-block count to zero, the count is reloaded with the loaded block length M.
- R4: `cfg_blk_is_dst` selects the block area: 0 means the source address and 1 means the destination address. After each block, the block-area address equals its loaded value.
- R5: An address moves by 2^`mem_size` per transfer, where size 0 is byte (1) and size 1 is word (2). It moves only if that side's increment enable is 1. It decrements when that side's direction bit is 1 and increments otherwise.
- R6: The remaining block count (`sts_blocks`) decreases by one at the end of each block.
- R7: When the last block completes, `chan_en` falls to 0.
- R8: When the last block completes with `cfg_irq_en` loaded as 1, `irq` rises. If `irq_clr` is high on that same edge, the set takes priority. With `cfg_irq_en` loaded as 0, `irq` stays low.
- R9: On the final transfer of the channel, the non-block address equals its loaded value moved by M·N−1 steps.
- R10: A request is ignored while `chan_en` is 0. It is also ignored while a burst is in progress, including on the edge of the burst's last transfer.
- R11: Once set, `irq` stays high until a cycle with `irq_clr` high.
- R12: While `active` is high and `mem_rdy` is low, the strobes stay asserted. The addresses and `sts_inner` hold their values.
- R13: After reset, `chan_en`, `active`, `irq`, `mem_rd` and `mem_wr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load all configuration fields; aborts any burst |
| cfg_en | input | 1 | Channel enable value taken on load |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_bsize | input | IW | Transfers per block M |
| cfg_bcount | input | OW | Number of blocks N |
| cfg_size | input | SW | Transfer width code (step is 2^size) |
| cfg_src_inc | input | 1 | Source address moves |
| cfg_src_dec | input | 1 | Source moves downward |
| cfg_dst_inc | input | 1 | Destination address moves |
| cfg_dst_dec | input | 1 | Destination moves downward |
| cfg_blk_is_dst | input | 1 | 1: destination is block area, 0: source |
| cfg_irq_en | input | 1 | Interrupt on completion enabled |
| irq_clr | input | 1 | Clear the interrupt |
| req | input | 1 | Transfer request (starts one block) |
| mem_rdy | input | 1 | Memory port accepts the current transfer |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_raddr | output | AW | Current source address |
| mem_waddr | output | AW | Current destination address |
| mem_size | output | SW | Transfer width code |
| active | output | 1 | Burst in progress |
| chan_en | output | 1 | Channel enabled |
| irq | output | 1 | Completion interrupt |
| sts_inner | output | IW | Transfers left in the current block |
| sts_blocks | output | OW | Blocks left |

## Verification
Two pairs of events can land on the same edge. The first is the last transfer of a block together with a new request. The bench holds `req` high through a whole burst, including its final transfer, then confirms that no second block starts and that only one block was consumed. The second is channel completion together with an interrupt clear. A one-transfer, one-block channel is started with `irq_clr` raised across its only transfer, and `irq` must read high afterwards because the set wins.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;
   localparam int NSIDES   = 2;
   localparam int SIDE_SRC = 0;
   localparam int SIDE_DST = 1;

   typedef struct packed {
      logic inc;   // address moves
      logic dec;   // moves downward when set
   } side_mode_t;
endpackage

// File: rtl/blk_dma_addr_step.sv
module blk_dma_addr_step
   import blkdma_pkg::*;
#(
   parameter int AW = 16,
   parameter int SW = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  side_mode_t    load_mode,
   input  logic          adv,
   input  logic          rewind,
   input  logic [SW-1:0] size,
   output logic [AW-1:0] addr
);
   logic [AW-1:0] base_q, addr_q, step;
   side_mode_t    mode_q;

   always_comb step = AW'(1) << size;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         addr_q <= '0;
         mode_q <= '0;
      end else if (load) begin
         base_q <= load_val;
         addr_q <= load_val;
         mode_q <= load_mode;
      end else if (adv) begin
         if (rewind)
            addr_q <= base_q;
         else if (mode_q.inc)
            addr_q <= mode_q.dec ? addr_q - step : addr_q + step;
      end
   end

   assign addr = addr_q;
endmodule

// File: rtl/blk_dma_counts.sv
module blk_dma_counts #(
   parameter int IW = 8,
   parameter int OW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [IW-1:0] ld_len,
   input  logic [OW-1:0] ld_blocks,
   input  logic          adv,
   output logic [IW-1:0] inner,
   output logic [OW-1:0] blocks,
   output logic          blk_last,
   output logic          chan_last
);
   logic [IW-1:0] inner_q, reload_q;
   logic [OW-1:0] blocks_q;

   assign blk_last  = adv && (inner_q == IW'(1));
   assign chan_last = blk_last && (blocks_q == OW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inner_q  <= '0;
         reload_q <= '0;
         blocks_q <= '0;
      end else if (load) begin
         inner_q  <= ld_len;
         reload_q <= ld_len;
         blocks_q <= ld_blocks;
      end else if (blk_last) begin
         inner_q  <= reload_q;
         blocks_q <= blocks_q - OW'(1);
      end else if (adv) begin
         inner_q  <= inner_q - IW'(1);
      end
   end

   assign inner  = inner_q;
   assign blocks = blocks_q;
endmodule

// File: rtl/blk_dma_ctrl.sv
module blk_dma_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic ld_en,
   input  logic ld_irq_en,
   input  logic req,
   input  logic blk_last,
   input  logic chan_last,
   input  logic irq_clr,
   output logic active,
   output logic chan_en,
   output logic irq
);
   logic active_q, en_q, irq_en_q, irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         en_q     <= 1'b0;
         irq_en_q <= 1'b0;
      end else if (load) begin
         active_q <= 1'b0;
         en_q     <= ld_en;
         irq_en_q <= ld_irq_en;
      end else if (blk_last) begin
         active_q <= 1'b0;
         if (chan_last) en_q <= 1'b0;
      end else if (req && en_q && !active_q) begin
         active_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_q <= 1'b0;
      else if (chan_last && irq_en_q && !load)
         irq_q <= 1'b1;
      else if (irq_clr)
         irq_q <= 1'b0;
   end

   assign active  = active_q;
   assign chan_en = en_q;
   assign irq     = irq_q;
endmodule

// File: rtl/blk_dma_seq.sv
module blk_dma_seq
   import blkdma_pkg::*;
#(
   parameter int AW = 16,
   parameter int IW = 8,
   parameter int OW = 16,
   parameter int SW = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_load,
   input  logic          cfg_en,
   input  logic [AW-1:0] cfg_src,
   input  logic [AW-1:0] cfg_dst,
   input  logic [IW-1:0] cfg_bsize,
   input  logic [OW-1:0] cfg_bcount,
   input  logic [SW-1:0] cfg_size,
   input  logic          cfg_src_inc,
   input  logic          cfg_src_dec,
   input  logic          cfg_dst_inc,
   input  logic          cfg_dst_dec,
   input  logic          cfg_blk_is_dst,
   input  logic          cfg_irq_en,
   input  logic          irq_clr,
   input  logic          req,
   input  logic          mem_rdy,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [AW-1:0] mem_raddr,
   output logic [AW-1:0] mem_waddr,
   output logic [SW-1:0] mem_size,
   output logic          active,
   output logic          chan_en,
   output logic          irq,
   output logic [IW-1:0] sts_inner,
   output logic [OW-1:0] sts_blocks
);
   localparam int MAX_SIZE = (1 << SW) - 1;

   if (AW < 2)          begin : g_bad_aw $error("AW must be at least 2"); end
   if (IW < 2)          begin : g_bad_iw $error("IW must be at least 2"); end
   if (OW < 2)          begin : g_bad_ow $error("OW must be at least 2"); end
   if (SW < 1 || MAX_SIZE >= AW) begin : g_bad_sw $error("SW out of range for AW"); end

   logic          adv, blk_last, chan_last, active_w;
   logic [SW-1:0] size_q;
   logic          blk_dst_q;
   logic [AW-1:0] ld_addr  [NSIDES];
   logic [AW-1:0] cur_addr [NSIDES];
   side_mode_t    ld_mode  [NSIDES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         size_q    <= '0;
         blk_dst_q <= 1'b0;
      end else if (cfg_load) begin
         size_q    <= cfg_size;
         blk_dst_q <= cfg_blk_is_dst;
      end
   end

   assign ld_addr[SIDE_SRC] = cfg_src;
   assign ld_addr[SIDE_DST] = cfg_dst;
   assign ld_mode[SIDE_SRC] = '{inc: cfg_src_inc, dec: cfg_src_dec};
   assign ld_mode[SIDE_DST] = '{inc: cfg_dst_inc, dec: cfg_dst_dec};

   assign adv = active_w && mem_rdy;

   for (genvar g = 0; g < NSIDES; g++) begin : g_side
      localparam logic IS_DST = (g == SIDE_DST);
      blk_dma_addr_step #(.AW(AW), .SW(SW)) u_step (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (cfg_load),
         .load_val  (ld_addr[g]),
         .load_mode (ld_mode[g]),
         .adv       (adv),
         .rewind    (blk_last && (blk_dst_q == IS_DST)),
         .size      (size_q),
         .addr      (cur_addr[g])
      );
   end

   blk_dma_counts #(.IW(IW), .OW(OW)) u_counts (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (cfg_load),
      .ld_len    (cfg_bsize),
      .ld_blocks (cfg_bcount),
      .adv       (adv),
      .inner     (sts_inner),
      .blocks    (sts_blocks),
      .blk_last  (blk_last),
      .chan_last (chan_last)
   );

   blk_dma_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (cfg_load),
      .ld_en     (cfg_en),
      .ld_irq_en (cfg_irq_en),
      .req       (req),
      .blk_last  (blk_last),
      .chan_last (chan_last),
      .irq_clr   (irq_clr),
      .active    (active_w),
      .chan_en   (chan_en),
      .irq       (irq)
   );

   assign active    = active_w;
   assign mem_rd    = active_w;
   assign mem_wr    = active_w;
   assign mem_raddr = cur_addr[SIDE_SRC];
   assign mem_waddr = cur_addr[SIDE_DST];
   assign mem_size  = size_q;
endmodule

// File: rtl/blk_dma_seq_chk.sv
module blk_dma_seq_chk #(
   parameter int AW = 16,
   parameter int IW = 8,
   parameter int OW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_load,
   input logic          irq_clr,
   input logic          mem_rdy,
   input logic          active,
   input logic          chan_en,
   input logic          irq,
   input logic [AW-1:0] mem_raddr,
   input logic [AW-1:0] mem_waddr,
   input logic [IW-1:0] sts_inner,
   input logic [OW-1:0] sts_blocks
);
   // R1
   inner_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active && mem_rdy && !cfg_load && sts_inner != IW'(1)
      |=> sts_inner == IW'($past(sts_inner) - IW'(1)));

   // R6
   blk_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active && mem_rdy && !cfg_load && sts_inner == IW'(1)
      |=> sts_blocks == OW'($past(sts_blocks) - OW'(1)));

   // R7
   chan_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active && mem_rdy && !cfg_load && sts_inner == IW'(1) && sts_blocks == OW'(1)
      |=> !chan_en && !active);

   // R10
   no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en && !active |=> !active);

   // R11
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !irq_clr |=> irq);

   // R12
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active && !mem_rdy && !cfg_load
      |=> active && $stable(mem_raddr) && $stable(mem_waddr) && $stable(sts_inner));
endmodule

bind blk_dma_seq blk_dma_seq_chk #(.AW(AW), .IW(IW), .OW(OW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_load   (cfg_load),
   .irq_clr    (irq_clr),
   .mem_rdy    (mem_rdy),
   .active     (active),
   .chan_en    (chan_en),
   .irq        (irq),
   .mem_raddr  (mem_raddr),
   .mem_waddr  (mem_waddr),
   .sts_inner  (sts_inner),
   .sts_blocks (sts_blocks)
);

// File: tb/tb_blk_dma_seq.sv
module tb_blk_dma_seq;
   localparam int AW = 16, IW = 8, OW = 16, SW = 1;

   typedef struct packed {
      logic [0:0]  size;
      logic        sinc, sdec, dinc, ddec, bdst;
      logic [7:0]  m;
      logic [15:0] n;
      logic [15:0] src, dst, lsrc, ldst, fsrc, fdst;
   } vec_t;

   localparam vec_t VECS [4] = '{
      '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd4, 16'd3,
        16'h0100, 16'h0200, 16'h0103, 16'h020B, 16'h0100, 16'h020C},
      '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'd3, 16'd2,
        16'h1000, 16'h0400, 16'h0FF6, 16'h0404, 16'h0FF4, 16'h0400},
      '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd2, 16'd4,
        16'h0050, 16'h0800, 16'h0050, 16'h07F2, 16'h0050, 16'h07F0},
      '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'd1, 16'd5,
        16'h0010, 16'h0030, 16'h0014, 16'h0030, 16'h0015, 16'h0030}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_load = 0, cfg_en = 0, cfg_src_inc = 0, cfg_src_dec = 0;
   logic cfg_dst_inc = 0, cfg_dst_dec = 0, cfg_blk_is_dst = 0, cfg_irq_en = 0;
   logic irq_clr = 0, req = 0, mem_rdy = 1;
   logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
   logic [IW-1:0] cfg_bsize = '0;
   logic [OW-1:0] cfg_bcount = '0;
   logic [SW-1:0] cfg_size = '0;
   logic mem_rd, mem_wr, active, chan_en, irq;
   logic [AW-1:0] mem_raddr, mem_waddr;
   logic [SW-1:0] mem_size;
   logic [IW-1:0] sts_inner;
   logic [OW-1:0] sts_blocks;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   blk_dma_seq #(.AW(AW), .IW(IW), .OW(OW), .SW(SW)) dut (.*);

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic load(input vec_t v, input bit en, input bit ie);
      @(negedge clk);
      cfg_size = v.size; cfg_src_inc = v.sinc; cfg_src_dec = v.sdec;
      cfg_dst_inc = v.dinc; cfg_dst_dec = v.ddec; cfg_blk_is_dst = v.bdst;
      cfg_bsize = v.m; cfg_bcount = v.n; cfg_src = v.src; cfg_dst = v.dst;
      cfg_en = en; cfg_irq_en = ie; cfg_load = 1;
      @(negedge clk);
      cfg_load = 0;
   endtask

   task automatic clear_irq();
      @(negedge clk); irq_clr = 1;
      @(negedge clk); irq_clr = 0;
   endtask

   // one request, then follow the burst; returns count and last addresses
   task automatic burst(output int cnt, output int ls, output int ld);
      cnt = 0; ls = 0; ld = 0;
      @(negedge clk); req = 1;
      @(negedge clk); req = 0;
      for (int g = 0; g < 1000 && active; g++) begin
         if (mem_rd && mem_wr && mem_rdy) begin
            cnt++; ls = mem_raddr; ld = mem_waddr;
         end
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int cnt, ls, ld;
      vec_t v;
      repeat (3) @(negedge clk);
      // R13 reset state
      chk(chan_en == 0, "R13 chan_en", chan_en, 0);
      chk(active == 0, "R13 active", active, 0);
      chk(irq == 0, "R13 irq", irq, 0);
      chk(mem_rd == 0 && mem_wr == 0, "R13 strobes", {mem_rd, mem_wr}, 0);
      rst_n = 1;

      // R10 request ignored while channel disabled
      @(negedge clk); req = 1;
      @(negedge clk); req = 0;
      @(negedge clk);
      chk(active == 0 && mem_rd == 0, "R10 disabled req", active, 0);

      // table walk
      foreach (VECS[i]) begin
         v = VECS[i];
         clear_irq();
         load(v, 1'b1, 1'b1);
         for (int b = 0; b < int'(v.n); b++) begin
            burst(cnt, ls, ld);
            chk(cnt == int'(v.m), "R2 burst length", cnt, v.m);
            chk(sts_inner == v.m, "R3 inner reload", sts_inner, v.m);
            chk(sts_blocks == OW'(int'(v.n) - 1 - b), "R6 block count",
                sts_blocks, int'(v.n) - 1 - b);
            if (b < int'(v.n) - 1)
               chk(chan_en == 1 && irq == 0, "R7 still enabled", {chan_en, irq}, 2'b10);
         end
         chk(chan_en == 0, "R7 channel off", chan_en, 0);
         chk(irq == 1, "R8 irq set", irq, 1);
         chk(ls == int'(v.lsrc), "R9 R5 last src", ls, v.lsrc);
         chk(ld == int'(v.ldst), "R9 R5 last dst", ld, v.ldst);
         chk(mem_raddr == v.fsrc, "R4 R5 final src", mem_raddr, v.fsrc);
         chk(mem_waddr == v.fdst, "R4 R5 final dst", mem_waddr, v.fdst);
      end

      // R11 irq sticky until clear
      repeat (5) @(negedge clk);
      chk(irq == 1, "R11 irq held", irq, 1);
      clear_irq();
      chk(irq == 0, "R11 irq cleared", irq, 0);

      // R12 stall: M=4 N=1, source byte increment, destination block area
      v = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd4, 16'd1,
            16'h0040, 16'h0900, 16'h0043, 16'h0900, 16'h0044, 16'h0900};
      load(v, 1'b1, 1'b0);
      @(negedge clk); req = 1;
      @(negedge clk); req = 0; mem_rdy = 0;
      repeat (3) @(negedge clk);
      chk(active == 1 && mem_rd == 1, "R12 strobe held", {active, mem_rd}, 2'b11);
      chk(mem_raddr == 16'h0040, "R12 addr held", mem_raddr, 16'h0040);
      chk(sts_inner == 4, "R12 R1 inner held", sts_inner, 4);
      mem_rdy = 1;
      @(negedge clk);
      chk(sts_inner == 3, "R1 inner dec", sts_inner, 3);
      chk(mem_raddr == 16'h0041, "R5 byte step", mem_raddr, 16'h0041);
      repeat (3) @(negedge clk);
      chk(active == 0 && mem_raddr == 16'h0044, "R2 stalled burst done", mem_raddr, 16'h0044);
      chk(irq == 0, "R8 irq disabled", irq, 0);

      // R10 request held through a whole burst, including its final transfer
      v = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd3, 16'd2,
            16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000};
      load(v, 1'b1, 1'b0);
      @(negedge clk); req = 1;
      cnt = 0;
      @(negedge clk);
      for (int g = 0; g < 100 && active; g++) begin
         if (mem_rd && mem_rdy) cnt++;
         @(negedge clk);
      end
      req = 0;
      repeat (3) @(negedge clk);
      chk(cnt == 3, "R2 R10 one burst", cnt, 3);
      chk(active == 0, "R10 no restart", active, 0);
      chk(sts_blocks == 1, "R10 one block used", sts_blocks, 1);
      chk(sts_inner == 3, "R3 reload", sts_inner, 3);

      // R8 completion and clear on the same edge: set wins
      v = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd1, 16'd1,
            16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000};
      load(v, 1'b1, 1'b1);
      chk(irq == 0, "R8 irq low before", irq, 0);
      @(negedge clk); req = 1;
      @(negedge clk); req = 0; irq_clr = 1;
      @(negedge clk); irq_clr = 0;
      chk(irq == 1, "R8 set beats clear", irq, 1);
      chk(chan_en == 0, "R7 single block done", chan_en, 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule